// File: doc/BRIEF.md
# Row-Latched Write Buffer with Upper-Block Lock

This block sits between a serial-memory protocol engine and a 512-byte non-volatile array. The engine opens a write command by presenting the start address. It then streams the data bytes of that command and finally signals the bus stop. The block gathers the bytes into an 8-entry row latch. On the stop it runs a self-timed program window. Busy is held high for that whole window, and the latched bytes go out to the array write port, one per clock, at the start of the window. The program time is a counter of `BASE_MS * CYC_PER_MS` clocks, so a bench can use a short count.

The burst-mode pin is sampled when the command opens and picks one of two modes. In row mode only the three low address bits advance, so a long burst wraps inside its 8-byte row and later bytes replace earlier ones. In burst mode, up to four bytes go to consecutive addresses from any start. If those bytes cross a 4-byte address group, the window doubles.

Two inputs are sampled at the stop:
- A write-block pin cancels the program window.
- A lock pin enables protection of the upper block, from a boundary set by the byte stored at the top address (1FFh) up to 1FFh. The block keeps a copy of that byte, taken from its own writes. The copy starts at FFh, matching an erased array.

Data input is valid/ready. A byte is taken on a clock where `byte_valid` and `byte_ready` are both high and neither `cmd_load` nor `cmd_stop` is high. `byte_ready` is high only when all three of these hold: a command is open, no program window runs, and the burst-mode cap is not reached. The engine may drop `byte_valid` at any time. A byte offered while `byte_ready` is low is not taken. Control pins are plain single-cycle strobes.

Top module: `rowlatch_prog`

## Requirements
- R1: After reset `busy`, `byte_ready` and `mem_we` are low and the stored top-byte copy reads FFh.
- R2: With `burst_mode` low at `cmd_load`, byte k of the command targets `{cmd_addr[8:3], (cmd_addr[2:0]+k) mod 8}`. When two bytes hit the same address, the later one is written.
- R3: With `burst_mode` high at `cmd_load`, byte k targets `{cmd_addr[8], (cmd_addr[7:0]+k) mod 256}`. `byte_ready` drops after the 4th byte, so a 5th offered byte is never taken.
- R4: A launched window holds `busy` high for exactly 10*`CYC_PER_MS` clocks, starting the clock after the stop. It holds 20*`CYC_PER_MS` clocks in burst mode when the first and last byte differ in address bits [7:2].
- R5: A stop with no byte taken since `cmd_load`, or a stop with no open command, starts no window and writes nothing.
- R6: With `wr_block` high at the stop, the command starts no window and leaves the array unchanged.
- R7: Protection applies when `lock_pin` is high at the stop and bit 2 of the stored top byte is 0. Bytes addressed from `100h + 8*top[7:3]` through 1FFh are then skipped, and the other bytes of the command are written. The decision uses the top byte as it was before the window began.
- R8: With `lock_pin` low at the stop, address 1FFh is written like any other byte, and that value becomes the new top byte.
- R9: While `busy` is high, `byte_ready` is low and `cmd_load`, `cmd_stop` and bytes are ignored. `mem_we` is high only while `busy` is high. No command is open after a window ends.
- R10: A one-byte command writes the same address and uses the short window in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_load | input | 1 | Opens a write command at `cmd_addr` |
| cmd_addr | input | 9 | Start address (bit 8 = block) |
| burst_mode | input | 1 | 1 = burst mode, 0 = row mode; sampled at `cmd_load` |
| byte_valid | input | 1 | Data byte offered |
| byte_ready | output | 1 | Data byte can be taken |
| byte_data | input | 8 | Data byte |
| cmd_stop | input | 1 | Bus stop strobe |
| wr_block | input | 1 | Cancels programming when high at the stop |
| lock_pin | input | 1 | Enables upper-block protection when high at the stop |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 9 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Program window active |

## Verification
The bench drives a row-mode burst of ten bytes. A design that advanced the full address would spill into the next row, and one that kept the first copy of a slot would lose the later bytes. Burst commands are chosen to straddle and not straddle a 4-byte group; a wrong span test shows up as a window of the wrong length. A burst that starts just below the lock boundary must have its upper half skipped and its lower half written. A command that writes the top byte while protection is still off must land, since the decision uses the byte stored before the window. Stops with no data, with the write block set, and pokes during a window must leave both busy and the array untouched.

// File: rtl/rowlatch_pkg.sv
package rowlatch_pkg;
  localparam int ADDR_W    = 9;
  localparam int DATA_W    = 8;
  localparam int FLAG_BIT  = 2;
  localparam int BOUND_LSB = 3;

  typedef logic [ADDR_W-1:0] mem_addr_t;
  typedef logic [DATA_W-1:0] mem_byte_t;

  typedef struct packed {
    logic      vld;
    mem_addr_t addr;
    mem_byte_t data;
  } slot_t;

  localparam mem_addr_t TOP_ADDR = '1;
  localparam mem_byte_t BOUND_MASK = mem_byte_t'({DATA_W{1'b1}} << BOUND_LSB);
endpackage

// File: rtl/rowlatch_collect.sv
module rowlatch_collect
  import rowlatch_pkg::*;
#(
  parameter int ROW_BYTES = 8,
  parameter int MB_MAX    = 4,
  parameter int SPAN_LSB  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  mem_addr_t                    load_addr,
  input  logic                         load_mb,
  input  logic                         take,
  input  mem_byte_t                    take_data,
  input  logic [$clog2(ROW_BYTES)-1:0] rd_idx,
  output slot_t                        rd_slot,
  output logic                         has_data,
  output logic                         mb_full,
  output logic                         spans_rows
);
  localparam int COL_W = $clog2(ROW_BYTES);
  localparam int CNT_W = $clog2(ROW_BYTES + 1);
  localparam int LO_W  = ADDR_W - 1;

  slot_t             slots [ROW_BYTES];
  mem_addr_t         base_q;
  logic [COL_W-1:0]  col_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              mb_q;

  mem_addr_t         cur_addr;
  logic [COL_W-1:0]  wr_idx;
  logic [LO_W-1:0]   last_lo;

  always_comb begin
    if (mb_q) begin
      cur_addr = {base_q[ADDR_W-1], base_q[LO_W-1:0] + LO_W'(cnt_q)};
      wr_idx   = cnt_q[COL_W-1:0];
    end else begin
      cur_addr = {base_q[ADDR_W-1:COL_W], col_q};
      wr_idx   = col_q;
    end
    last_lo = base_q[LO_W-1:0] + LO_W'(cnt_q) - LO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      col_q  <= '0;
      cnt_q  <= '0;
      mb_q   <= 1'b0;
    end else if (load) begin
      base_q <= load_addr;
      col_q  <= load_addr[COL_W-1:0];
      cnt_q  <= '0;
      mb_q   <= load_mb;
    end else if (take) begin
      col_q <= col_q + COL_W'(1);
      if (cnt_q != CNT_W'(ROW_BYTES)) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROW_BYTES; i++) slots[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < ROW_BYTES; i++) slots[i].vld <= 1'b0;
    end else if (take) begin
      for (int i = 0; i < ROW_BYTES; i++)
        if (wr_idx == COL_W'(i)) slots[i] <= '{vld: 1'b1, addr: cur_addr, data: take_data};
    end
  end

  assign rd_slot    = slots[rd_idx];
  assign has_data   = (cnt_q != '0);
  assign mb_full    = mb_q && (cnt_q >= CNT_W'(MB_MAX));
  assign spans_rows = mb_q && has_data &&
                      ((base_q[LO_W-1:0] >> SPAN_LSB) != (last_lo >> SPAN_LSB));
endmodule

// File: rtl/rowlatch_guard.sv
module rowlatch_guard
  import rowlatch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      arm,
  input  logic      lock_pin,
  input  logic      wr_en,
  input  mem_addr_t wr_addr,
  input  mem_byte_t wr_data,
  input  mem_addr_t chk_addr,
  output logic      locked
);
  mem_byte_t top_q;
  logic      en_q;
  mem_addr_t bnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '1;
    end else if (wr_en && wr_addr == TOP_ADDR) begin
      top_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      bnd_q <= TOP_ADDR;
    end else if (arm) begin
      en_q  <= lock_pin && !top_q[FLAG_BIT];
      bnd_q <= {1'b1, top_q & BOUND_MASK};
    end
  end

  assign locked = en_q && (chk_addr >= bnd_q);
endmodule

// File: rtl/rowlatch_seq.sv
module rowlatch_seq #(
  parameter int CYC_PER_MS = 50000,
  parameter int BASE_MS    = 10,
  parameter int ROW_BYTES  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           launch,
  input  logic                           long_cyc,
  output logic                           busy,
  output logic [$clog2(ROW_BYTES)-1:0]   slot_idx,
  output logic                           slot_active
);
  localparam int SHORT_CYC = BASE_MS * CYC_PER_MS;
  localparam int LONG_CYC  = 2 * SHORT_CYC;
  localparam int TMR_W     = $clog2(LONG_CYC + 1);
  localparam int IDX_W     = $clog2(ROW_BYTES + 1);
  localparam int COL_W     = $clog2(ROW_BYTES);

  logic [TMR_W-1:0] tmr_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      tmr_q <= '0;
      idx_q <= '0;
    end else if (!busy) begin
      if (launch) begin
        busy  <= 1'b1;
        tmr_q <= long_cyc ? TMR_W'(LONG_CYC - 1) : TMR_W'(SHORT_CYC - 1);
        idx_q <= '0;
      end
    end else begin
      if (tmr_q == '0) busy <= 1'b0;
      else             tmr_q <= tmr_q - TMR_W'(1);
      if (idx_q != IDX_W'(ROW_BYTES)) idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign slot_idx    = idx_q[COL_W-1:0];
  assign slot_active = busy && (idx_q < IDX_W'(ROW_BYTES));
endmodule

// File: rtl/rowlatch_prog.sv
module rowlatch_prog
  import rowlatch_pkg::*;
#(
  parameter int CYC_PER_MS = 50000,
  parameter int BASE_MS    = 10,
  parameter int ROW_BYTES  = 8,
  parameter int MB_MAX     = 4,
  parameter int SPAN_LSB   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_load,
  input  logic [8:0] cmd_addr,
  input  logic       burst_mode,
  input  logic       byte_valid,
  output logic       byte_ready,
  input  logic [7:0] byte_data,
  input  logic       cmd_stop,
  input  logic       wr_block,
  input  logic       lock_pin,
  output logic       mem_we,
  output logic [8:0] mem_addr,
  output logic [7:0] mem_wdata,
  output logic       busy
);
  localparam int COL_W = $clog2(ROW_BYTES);

  logic             open_q;
  logic             accept_load;
  logic             take;
  logic             launch;
  logic             has_data;
  logic             mb_full;
  logic             spans_rows;
  logic             locked;
  logic             slot_active;
  logic [COL_W-1:0] slot_idx;
  slot_t            cur_slot;

  assign accept_load = cmd_load && !busy && !cmd_stop;
  assign byte_ready  = open_q && !busy && !mb_full;
  assign take        = byte_valid && byte_ready && !cmd_stop && !cmd_load;
  assign launch      = cmd_stop && open_q && has_data && !wr_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           open_q <= 1'b0;
    else if (cmd_stop)    open_q <= 1'b0;
    else if (accept_load) open_q <= 1'b1;
  end

  rowlatch_collect #(
    .ROW_BYTES(ROW_BYTES), .MB_MAX(MB_MAX), .SPAN_LSB(SPAN_LSB)
  ) u_collect (
    .clk(clk), .rst_n(rst_n),
    .load(accept_load), .load_addr(cmd_addr), .load_mb(burst_mode),
    .take(take), .take_data(byte_data),
    .rd_idx(slot_idx), .rd_slot(cur_slot),
    .has_data(has_data), .mb_full(mb_full), .spans_rows(spans_rows)
  );

  rowlatch_seq #(
    .CYC_PER_MS(CYC_PER_MS), .BASE_MS(BASE_MS), .ROW_BYTES(ROW_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .long_cyc(spans_rows),
    .busy(busy), .slot_idx(slot_idx), .slot_active(slot_active)
  );

  rowlatch_guard u_guard (
    .clk(clk), .rst_n(rst_n),
    .arm(launch), .lock_pin(lock_pin),
    .wr_en(mem_we), .wr_addr(mem_addr), .wr_data(mem_wdata),
    .chk_addr(cur_slot.addr), .locked(locked)
  );

  assign mem_we    = slot_active && cur_slot.vld && !locked;
  assign mem_addr  = cur_slot.addr;
  assign mem_wdata = cur_slot.data;
endmodule

// File: rtl/rowlatch_chk.sv
module rowlatch_chk #(
  parameter int CYC_PER_MS = 50000,
  parameter int BASE_MS    = 10,
  parameter int MB_MAX     = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_load,
  input logic       burst_mode,
  input logic       byte_valid,
  input logic       byte_ready,
  input logic       cmd_stop,
  input logic       wr_block,
  input logic       lock_pin,
  input logic       mem_we,
  input logic [8:0] mem_addr,
  input logic [7:0] mem_wdata,
  input logic       busy
);
  localparam int SHORT_CYC = BASE_MS * CYC_PER_MS;
  localparam int LONG_CYC  = 2 * SHORT_CYC;
  localparam int RUN_W     = $clog2(LONG_CYC + 2);

  logic [RUN_W-1:0] run_q;
  logic [3:0]       acc_q;
  logic             mb_c;
  logic [7:0]       top_c;
  logic             cap_en;
  logic [8:0]       cap_bnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      acc_q   <= '0;
      mb_c    <= 1'b0;
      top_c   <= 8'hFF;
      cap_en  <= 1'b0;
      cap_bnd <= 9'h1FF;
    end else begin
      run_q <= busy ? run_q + RUN_W'(1) : '0;
      if (cmd_load && !busy && !cmd_stop) begin
        acc_q <= '0;
        mb_c  <= burst_mode;
      end else if (byte_valid && byte_ready && !cmd_stop && !cmd_load && acc_q != 4'hF) begin
        acc_q <= acc_q + 4'd1;
      end
      if (mem_we && mem_addr == 9'h1FF) top_c <= mem_wdata;
      if (cmd_stop && !busy) begin
        cap_en  <= lock_pin && !top_c[2];
        cap_bnd <= {1'b1, top_c & 8'hF8};
      end
    end
  end

  assert_we_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  assert_no_ready_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !byte_ready);
  assert_window_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == RUN_W'(SHORT_CYC) || run_q == RUN_W'(LONG_CYC)));
  assert_start_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_stop));
  assert_block_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && wr_block && !busy) |=> !busy);
  assert_empty_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && !busy && acc_q == 4'd0) |=> !busy);
  assert_burst_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_c && acc_q >= 4'(MB_MAX)) |-> !byte_ready);
  assert_lock_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && cap_en) |-> (mem_addr < cap_bnd));
endmodule

bind rowlatch_prog rowlatch_chk #(
  .CYC_PER_MS(CYC_PER_MS), .BASE_MS(BASE_MS), .MB_MAX(MB_MAX)
) u_chk (.*);

// File: tb/rowlatch_prog_tb.sv
`timescale 1ns/1ps
module rowlatch_prog_tb;
  localparam int CPM   = 4;
  localparam int SHORT = 10 * CPM;
  localparam int LONG  = 20 * CPM;
  localparam int MB    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_load = 0, burst_mode = 0, byte_valid = 0, cmd_stop = 0, wr_block = 0, lock_pin = 0;
  logic [8:0] cmd_addr = '0;
  logic [7:0] byte_data = '0;
  logic byte_ready, mem_we, busy;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  rowlatch_prog #(.CYC_PER_MS(CPM)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_addr(cmd_addr),
    .burst_mode(burst_mode), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .cmd_stop(cmd_stop), .wr_block(wr_block),
    .lock_pin(lock_pin), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] exp_mem [512];
  logic [7:0] act_mem [512];
  int m_left = 0, m_n = 0;
  bit m_open = 0, m_mb = 0, m_lk = 0, m_span = 0;
  logic [8:0] m_start, m_a, m_bnd;
  logic [8:0] q_a [$];
  logic [7:0] q_d [$];

  initial for (int i = 0; i < 512; i++) begin exp_mem[i] = 8'hFF; act_mem[i] = 8'hFF; end

  function automatic bit m_ready();
    return m_open && m_left == 0 && !(m_mb && m_n >= MB);
  endfunction

  always @(posedge clk) begin
    if (mem_we) act_mem[mem_addr] = mem_wdata;
    if (!rst_n) begin
      m_left = 0; m_open = 0; m_n = 0;
    end else if (m_left > 0) begin
      m_left--;
    end else if (cmd_stop) begin
      if (m_open && m_n > 0 && !wr_block) begin
        m_lk  = lock_pin && !exp_mem[511][2];
        m_bnd = {1'b1, exp_mem[511] & 8'hF8};
        m_span = 0;
        foreach (q_a[i]) if (m_mb && q_a[i][7:2] != q_a[0][7:2]) m_span = 1;
        m_left = m_span ? LONG : SHORT;
        foreach (q_a[i]) if (!(m_lk && q_a[i] >= m_bnd)) exp_mem[q_a[i]] = q_d[i];
      end
      m_open = 0;
    end else if (cmd_load) begin
      m_open = 1; m_mb = burst_mode; m_start = cmd_addr; m_n = 0;
      q_a.delete(); q_d.delete();
    end else if (byte_valid && m_ready()) begin
      m_a = m_mb ? {m_start[8], 8'(m_start[7:0] + m_n)} : {m_start[8:3], 3'(m_start[2:0] + m_n)};
      q_a.push_back(m_a); q_d.push_back(byte_data);
      m_n++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(busy === (m_left > 0), "R4 busy vs model", busy, m_left > 0);
      check(byte_ready === m_ready(), "R9 byte_ready vs model", byte_ready, m_ready());
    end
  end

  task automatic mem_check(input string what);
    int bad = -1;
    for (int i = 0; i < 512; i++) if (bad < 0 && act_mem[i] !== exp_mem[i]) bad = i;
    check(bad < 0, what, bad < 0 ? 0 : act_mem[bad], bad < 0 ? 0 : exp_mem[bad]);
  endtask

  task automatic run_cmd(input bit mb, input logic [8:0] a, input int n, input logic [7:0] d0,
                         input bit wc, input bit lk, input int exp_len, input bit poke, input string tag);
    int len;
    @(negedge clk); cmd_load = 1; cmd_addr = a; burst_mode = mb;
    @(negedge clk); cmd_load = 0;
    for (int i = 0; i < n; i++) begin
      byte_valid = 1; byte_data = d0 + 8'(i * 7);
      #1;
      if (mb) check(byte_ready == (i < MB), {tag, " R3 ready cap"}, byte_ready, i < MB);
      @(negedge clk);
    end
    byte_valid = 0; wr_block = wc; lock_pin = lk; cmd_stop = 1;
    @(negedge clk); cmd_stop = 0; wr_block = 0;
    len = 0;
    while (busy && len < 1000) begin
      if (poke && len == 3) begin cmd_load = 1; cmd_addr = 9'h000; end
      if (poke && len == 4) begin cmd_load = 0; byte_valid = 1; byte_data = 8'h99; end
      if (poke && len == 5) begin byte_valid = 0; cmd_stop = 1; end
      if (poke && len == 6) cmd_stop = 0;
      len++;
      @(negedge clk);
    end
    check(len == exp_len, {tag, " R4 window length"}, len, exp_len);
    @(negedge clk);
    check(byte_ready == 0, {tag, " R9 closed after"}, byte_ready, 0);
    mem_check({tag, " array image"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && byte_ready == 0 && mem_we == 0, "R1 reset outputs", {busy, byte_ready, mem_we}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R2 row mode
    run_cmd(0, 9'h013, 3, 8'h10, 0, 0, SHORT, 0, "R2 row 3 bytes");
    run_cmd(0, 9'h05E, 10, 8'h20, 0, 0, SHORT, 0, "R2 row wrap");
    check(act_mem[9'h05E] == 8'h20 + 8'd56, "R2 wrap later wins", act_mem[9'h05E], 8'h20 + 8'd56);
    // R3/R4 burst mode
    run_cmd(1, 9'h0A1, 4, 8'h30, 0, 0, LONG, 0, "R4 burst span");
    run_cmd(1, 9'h0A4, 4, 8'h40, 0, 0, SHORT, 0, "R4 burst one group");
    run_cmd(1, 9'h020, 6, 8'h50, 0, 0, SHORT, 0, "R3 burst cap");
    check(act_mem[9'h024] == 8'hFF, "R3 fifth byte not written", act_mem[9'h024], 8'hFF);
    run_cmd(1, 9'h0FE, 3, 8'h60, 0, 0, LONG, 0, "R3 burst block wrap");
    check(act_mem[9'h000] == 8'h60 + 8'd14, "R3 wrap stays in block", act_mem[9'h000], 8'h60 + 8'd14);
    // R10 single byte either mode
    run_cmd(0, 9'h033, 1, 8'h5A, 0, 0, SHORT, 0, "R10 single row");
    run_cmd(1, 9'h044, 1, 8'h5B, 0, 0, SHORT, 0, "R10 single burst");
    check(act_mem[9'h044] == 8'h5B, "R10 burst single value", act_mem[9'h044], 8'h5B);
    // R5 empty stop, stop with nothing open
    run_cmd(0, 9'h050, 0, 8'h00, 0, 0, 0, 0, "R5 empty stop");
    @(negedge clk); cmd_stop = 1; @(negedge clk); cmd_stop = 0;
    @(negedge clk); check(busy == 0, "R5 stop with no command", busy, 0);
    // R6 write block
    run_cmd(0, 9'h070, 2, 8'h70, 1, 0, 0, 0, "R6 write block");
    check(act_mem[9'h070] == 8'hFF, "R6 untouched", act_mem[9'h070], 8'hFF);
    // R9 pokes during a window
    run_cmd(0, 9'h080, 2, 8'h80, 0, 0, SHORT, 1, "R9 ignore while busy");
    check(act_mem[9'h000] == 8'h6E, "R9 poke byte not written", act_mem[9'h000], 8'h6E);
    // R8 set top byte with lock low: boundary 1C8h, flag 0
    run_cmd(0, 9'h1FF, 1, 8'hC8, 0, 0, SHORT, 0, "R8 top byte");
    check(act_mem[9'h1FF] == 8'hC8, "R8 top byte written", act_mem[9'h1FF], 8'hC8);
    // R7 protection
    run_cmd(0, 9'h1C0, 8, 8'h01, 0, 1, SHORT, 0, "R7 below boundary");
    check(act_mem[9'h1C7] == 8'h01 + 8'd49, "R7 below written", act_mem[9'h1C7], 8'h01 + 8'd49);
    run_cmd(0, 9'h1C8, 8, 8'h02, 0, 1, SHORT, 0, "R7 row at boundary");
    check(act_mem[9'h1C8] == 8'hFF, "R7 boundary skipped", act_mem[9'h1C8], 8'hFF);
    run_cmd(1, 9'h1C6, 4, 8'h03, 0, 1, LONG, 0, "R7 burst across boundary");
    check(act_mem[9'h1C6] == 8'h03 && act_mem[9'h1C9] == 8'hFF, "R7 partial burst",
          {act_mem[9'h1C6], act_mem[9'h1C9]}, {8'h03, 8'hFF});
    run_cmd(0, 9'h1FF, 1, 8'h00, 0, 1, SHORT, 0, "R7 top locked");
    check(act_mem[9'h1FF] == 8'hC8, "R7 top byte kept", act_mem[9'h1FF], 8'hC8);
    run_cmd(0, 9'h1FF, 1, 8'hFC, 0, 0, SHORT, 0, "R8 top rewrite");
    check(act_mem[9'h1FF] == 8'hFC, "R8 top byte disabled", act_mem[9'h1FF], 8'hFC);
    run_cmd(0, 9'h1F8, 8, 8'hC7, 0, 1, SHORT, 0, "R7 snapshot before window");
    check(act_mem[9'h1FF] == 8'hF8, "R7 snapshot lets top land", act_mem[9'h1FF], 8'hF8);
    run_cmd(0, 9'h1F8, 1, 8'h11, 0, 1, SHORT, 0, "R7 new lock active");
    check(act_mem[9'h1F8] == 8'hC7, "R7 new boundary holds", act_mem[9'h1F8], 8'hC7);
    run_cmd(0, 9'h0C0, 2, 8'hA0, 0, 1, SHORT, 0, "R7 lower block free");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule